// File: doc/BRIEF.md
# Capture/Compare Timer

This block is a counter peripheral with a small byte-wide register bus. A free-running count register advances on one of four count sources. Three are the system clock divided by 4, 8 or 16. The fourth is the rising edge of an external toggle input. Software reads the count and uses one shared data register in one of two ways. In interval mode the data register holds a compare value, and the counter restarts from zero on a match. In the capture modes the data register latches the count whenever the capture pin shows a selected edge, and the counter keeps running.

There are two interrupt request outputs. The overflow request is a single-cycle pulse raised when the counter wraps, and hardware clears it. The event request comes from a sticky pending flag that is set by a match or a capture. That flag drops only when software writes 0 to it. Each request has its own enable bit in the control register.

Top module: `capture_timer`

## Requirements
- R1: While reset is held, and before any count source has ticked, the control register (address 0) reads 0x00, the data and counter bytes (addresses 1 to 4) read 0, and both interrupt outputs are low.
- R2: Control bits [7:6] = 00, 01 and 10 advance the counter once every 4, 8 and 16 clock cycles respectively, from a free-running prescaler.
- R3: Control bits [7:6] = 11 advance the counter by exactly one for each rising edge of `tog_pin`, after a two-stage synchronizer. Falling edges do not advance it.
- R4: With control bits [5:4] = 00 (interval), a count tick that finds the counter equal to the data register sets the counter to 0 and sets the pending flag (control bit 0).
- R5: With control bits [5:4] = 01, 10 or 11, a synchronized rising, falling or either edge of `cap_pin` respectively copies the counter into the data register and sets the pending flag. Edges of the other polarity, and all capture-pin edges in interval mode, change neither.
- R6: In the capture modes the counter keeps incrementing after captures and wraps from all ones to zero.
- R7: Writing control bit 3 = 1 clears the counter and takes priority over a tick in the same cycle. Writing bit 3 = 0 leaves the counter unchanged. Bit 3 always reads 0.
- R8: Writing control bit 0 = 0 clears the pending flag and writing 1 leaves it unchanged. A set event in the same cycle as a clearing write leaves the flag set.
- R9: `irq_evt` is high exactly while the pending flag and control bit 1 are both 1.
- R10: `irq_ovf` is a one-cycle pulse, raised in the cycle after the counter wraps from all ones to zero by incrementing, and only when control bit 2 is 1. A reset by an interval match never raises it.
- R11: Address 1 holds data bits [7:0] and address 2 holds data bits [CNT_W-1:8] (upper read bits zero). Both are writable. Addresses 3 and 4 read counter bits [7:0] and [CNT_W-1:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| tog_pin | input | 1 | Asynchronous external count input |
| irq_ovf | output | 1 | Overflow interrupt pulse |
| irq_evt | output | 1 | Match/capture interrupt request |

## Verification
The collision that matters is a qualified capture edge arriving in the same clock cycle as a software write that clears the pending flag. The bench first counts the synchronizer latency on the capture pin, then times a control write with bit 0 = 0 to land on exactly the edge where the capture fires. It judges the result by reading back that the flag is still 1 and that the data register now holds the count. A second collision, a counter-clear write against a running count, is judged by the counter reading zero straight afterwards.

// File: rtl/tm_pkg.sv
package tm_pkg;
   typedef enum logic [1:0] {
      MODE_INTERVAL = 2'b00,
      MODE_CAP_RISE = 2'b01,
      MODE_CAP_FALL = 2'b10,
      MODE_CAP_BOTH = 2'b11
   } tm_mode_e;

   typedef enum logic [1:0] {
      SRC_DIV_A = 2'b00,
      SRC_DIV_B = 2'b01,
      SRC_DIV_C = 2'b10,
      SRC_EXT   = 2'b11
   } tm_src_e;

   localparam int CTL_PEND  = 0;
   localparam int CTL_EVTEN = 1;
   localparam int CTL_OVFEN = 2;
   localparam int CTL_CLR   = 3;
endpackage

// File: rtl/tm_sync.sv
module tm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tm_tick_gen.sv
module tm_tick_gen
   import tm_pkg::*;
#(
   parameter int DIV_LOG2_MIN = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  tm_src_e src,
   input  logic    tog_pin,
   output logic    tick
);
   localparam int PRE_W = DIV_LOG2_MIN + 2;

   if (DIV_LOG2_MIN < 1) begin : g_bad_div
      $error("tm_tick_gen: DIV_LOG2_MIN must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;
   logic [2:0]       rate_tick;
   logic             tog_s, tog_prev_q, tog_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar g = 0; g < 3; g++) begin : g_rate
      assign rate_tick[g] = &pre_q[DIV_LOG2_MIN+g-1:0];
   end

   tm_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (tog_pin),
      .q    (tog_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_prev_q <= 1'b0;
      else        tog_prev_q <= tog_s;
   end

   assign tog_rise = tog_s & ~tog_prev_q;

   always_comb begin
      case (src)
         SRC_DIV_A: tick = rate_tick[0];
         SRC_DIV_B: tick = rate_tick[1];
         SRC_DIV_C: tick = rate_tick[2];
         default:   tick = tog_rise;
      endcase
   end
endmodule

// File: rtl/tm_cap_qual.sv
module tm_cap_qual
   import tm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  tm_mode_e mode,
   input  logic     cap_pin,
   output logic     cap_evt
);
   logic cap_s, cap_prev_q, rise, fall;

   tm_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (cap_pin),
      .q    (cap_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_prev_q <= 1'b0;
      else        cap_prev_q <= cap_s;
   end

   assign rise = cap_s & ~cap_prev_q;
   assign fall = ~cap_s & cap_prev_q;

   always_comb begin
      case (mode)
         MODE_CAP_RISE: cap_evt = rise;
         MODE_CAP_FALL: cap_evt = fall;
         MODE_CAP_BOTH: cap_evt = rise | fall;
         default:       cap_evt = 1'b0;
      endcase
   end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
   import tm_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int ADDR_W       = 3,
   parameter int SYNC_STAGES  = 2,
   parameter int DIV_LOG2_MIN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              cap_pin,
   input  logic              tog_pin,
   output logic              irq_ovf,
   output logic              irq_evt
);
   localparam int HI_W = CNT_W - 8;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_DLO  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_DHI  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(4);

   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
      $error("capture_timer: CNT_W must lie in 9..16");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("capture_timer: ADDR_W must be at least 3");
   end

   tm_src_e          src_q;
   tm_mode_e         mode_q;
   logic             ovf_en_q, evt_en_q, pend_q, irq_ovf_q;
   logic [CNT_W-1:0] cnt_q, cnt_d, data_q, data_d;
   logic             tick, cap_evt, ctrl_wr, cnt_clr, match, ovf_evt, evt_set;

   tm_tick_gen #(.DIV_LOG2_MIN(DIV_LOG2_MIN), .SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_q),
      .tog_pin(tog_pin),
      .tick   (tick)
   );

   tm_cap_qual #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode_q),
      .cap_pin(cap_pin),
      .cap_evt(cap_evt)
   );

   assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
   assign cnt_clr = ctrl_wr && bus_wdata[CTL_CLR];
   assign match   = (mode_q == MODE_INTERVAL) && (cnt_q == data_q);
   assign ovf_evt = tick && !cnt_clr && !match && (cnt_q == '1);
   assign evt_set = cap_evt || (tick && match && !cnt_clr);

   always_comb begin
      cnt_d = cnt_q;
      if (cnt_clr)    cnt_d = '0;
      else if (tick)  cnt_d = match ? '0 : cnt_q + 1'b1;
   end

   always_comb begin
      data_d = data_q;
      if (cap_evt) begin
         data_d = cnt_q;
      end else if (bus_wr) begin
         if (bus_addr == A_DLO) data_d[7:0]       = bus_wdata;
         if (bus_addr == A_DHI) data_d[CNT_W-1:8] = bus_wdata[HI_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q     <= SRC_DIV_A;
         mode_q    <= MODE_INTERVAL;
         ovf_en_q  <= 1'b0;
         evt_en_q  <= 1'b0;
         pend_q    <= 1'b0;
         cnt_q     <= '0;
         data_q    <= '0;
         irq_ovf_q <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            src_q    <= tm_src_e'(bus_wdata[7:6]);
            mode_q   <= tm_mode_e'(bus_wdata[5:4]);
            ovf_en_q <= bus_wdata[CTL_OVFEN];
            evt_en_q <= bus_wdata[CTL_EVTEN];
         end
         if (evt_set)                             pend_q <= 1'b1;
         else if (ctrl_wr && !bus_wdata[CTL_PEND]) pend_q <= 1'b0;
         cnt_q     <= cnt_d;
         data_q    <= data_d;
         irq_ovf_q <= ovf_evt && ovf_en_q;
      end
   end

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = {src_q, mode_q, 1'b0, ovf_en_q, evt_en_q, pend_q};
         A_DLO:   bus_rdata = data_q[7:0];
         A_DHI:   bus_rdata = 8'(data_q[CNT_W-1:8]);
         A_CLO:   bus_rdata = cnt_q[7:0];
         A_CHI:   bus_rdata = 8'(cnt_q[CNT_W-1:8]);
         default: bus_rdata = 8'h00;
      endcase
   end

   assign irq_ovf = irq_ovf_q;
   assign irq_evt = pend_q && evt_en_q;

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (cnt_q == '0));

   assert_match_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_clr && mode_q == MODE_INTERVAL && cnt_q == data_q) |=> (cnt_q == '0 && pend_q));

   assert_capture_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (pend_q && data_q == $past(cnt_q)));

   assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !(ctrl_wr && !bus_wdata[CTL_PEND])) |=> pend_q);

   assert_run_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_clr && mode_q != MODE_INTERVAL) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   assert_ovf_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |=> !irq_ovf);

   assert_ovf_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |-> (cnt_q == '0));
endmodule

// File: tb/sim_capture_timer.sv
`timescale 1ns/1ps
module sim_capture_timer;
   localparam int CW = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cap_pin = 1'b0;
   logic       tog_pin = 1'b0;
   logic       irq_ovf, irq_evt;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   capture_timer #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
      .tog_pin(tog_pin), .irq_ovf(irq_ovf), .irq_evt(irq_evt)
   );

   // {mode[11:10], start level[9], ext pulses[8:1], capture expected[0]}
   localparam logic [11:0] VEC [7] = '{
      {2'b01, 1'b0, 8'd3, 1'b1},
      {2'b01, 1'b1, 8'd4, 1'b0},
      {2'b10, 1'b1, 8'd5, 1'b1},
      {2'b10, 1'b0, 8'd6, 1'b0},
      {2'b11, 1'b0, 8'd7, 1'b1},
      {2'b11, 1'b1, 8'd2, 1'b1},
      {2'b00, 1'b0, 8'd5, 1'b0}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      @(negedge clk);
      bus_addr = a;
      #1 v = int'(bus_rdata);
   endtask

   task automatic rd_cnt(output int v);
      int lo, hi;
      rd(3'd3, lo);
      rd(3'd4, hi);
      v = hi * 256 + lo;
   endtask

   task automatic pulse_tog();
      tog_pin = 1'b1;
      repeat (4) @(negedge clk);
      tog_pin = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #750us;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired (all requirements)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int v, c0, c1, lo, hi, pulses;
      // R1 reset state, read while reset is held
      repeat (3) @(negedge clk);
      rd(3'd0, v); check("R1 ctrl", v, 0);
      for (int a = 1; a <= 4; a++) begin
         rd(3'(a), v); check("R1 data/count byte", v, 0);
      end
      check("R1 irq_ovf", int'(irq_ovf), 0);
      check("R1 irq_evt", int'(irq_evt), 0);
      @(negedge clk) rst_n = 1'b1;

      // Vector table: R5 capture qualification, R3 ext counting
      for (int i = 0; i < 7; i++) begin
         logic [11:0] vv;
         vv = VEC[i];
         cap_pin = vv[9];
         repeat (6) @(negedge clk);
         wr(3'd0, {2'b11, vv[11:10], 4'b1000});
         wr(3'd1, 8'h55);
         wr(3'd2, 8'h01);
         for (int j = 0; j < int'(vv[8:1]); j++) pulse_tog();
         rd_cnt(v); check("R3 ext edge count", v, int'(vv[8:1]));
         cap_pin = ~vv[9];
         repeat (6) @(negedge clk);
         rd(3'd0, v); check("R5 pending after edge", v & 1, int'(vv[0]));
         rd(3'd1, lo); rd(3'd2, hi);
         check("R5 data after edge", hi * 256 + lo, vv[0] ? int'(vv[8:1]) : 'h155);
         check("R11 data high byte width", hi & 8'hFC, 0);
      end

      // R2 prescaler ratios, capture mode so no match restarts
      for (int s = 0; s < 3; s++) begin
         wr(3'd0, {2'(s), 2'b01, 4'b1000});
         rd(3'd3, c0);
         repeat (63) @(negedge clk);
         rd(3'd3, c1);
         check("R2 ticks per 64 cycles", (c1 - c0) & 8'hFF, 16 >> s);
      end

      // R7 clear and no-effect write, ext source
      wr(3'd0, 8'b11_01_1_000);
      pulse_tog(); pulse_tog();
      wr(3'd0, 8'b11_01_0_000);
      rd_cnt(v); check("R7 write 0 keeps count", v, 2);
      rd(3'd0, v); check("R7 bit 3 reads 0", v, 8'b11_01_0_000);
      wr(3'd0, 8'b11_01_1_000);
      rd_cnt(v); check("R7 clear", v, 0);

      // R4 interval match, R10 no overflow from match
      wr(3'd0, 8'b11_00_1_100);
      wr(3'd1, 8'h03); wr(3'd2, 8'h00);
      pulse_tog(); pulse_tog(); pulse_tog();
      rd_cnt(v); check("R4 count before match", v, 3);
      rd(3'd0, v); check("R4 no pending before match", v & 1, 0);
      pulses = 0;
      tog_pin = 1'b1;
      for (int k = 0; k < 4; k++) begin @(negedge clk); pulses += int'(irq_ovf); end
      tog_pin = 1'b0;
      for (int k = 0; k < 4; k++) begin @(negedge clk); pulses += int'(irq_ovf); end
      rd_cnt(v); check("R4 match restarts", v, 0);
      rd(3'd0, v); check("R4 match sets pending", v & 1, 1);
      check("R10 no pulse on match", pulses, 0);

      // R9 enable gating, R8 write 1 keeps / write 0 clears
      check("R9 irq_evt disabled", int'(irq_evt), 0);
      wr(3'd0, 8'b11_00_0_011);
      check("R9 irq_evt enabled", int'(irq_evt), 1);
      rd(3'd0, v); check("R8 write 1 keeps pending", v & 1, 1);
      wr(3'd0, 8'b11_00_0_001);
      check("R9 irq_evt re-disabled", int'(irq_evt), 0);
      wr(3'd0, 8'b11_00_0_010);
      rd(3'd0, v); check("R8 write 0 clears", v & 1, 0);
      check("R9 irq_evt after clear", int'(irq_evt), 0);

      // R8 collision: capture and clearing write on the same edge
      cap_pin = 1'b0;
      wr(3'd0, 8'b11_01_1_000);
      pulse_tog(); pulse_tog(); pulse_tog(); pulse_tog();
      @(negedge clk) cap_pin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'b11_01_0_000;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(3'd0, v); check("R8 capture beats clear", v & 1, 1);
      rd(3'd1, v); check("R8 collision data", v, 4);

      // R10/R6 overflow wrap in capture mode, div4 source
      cap_pin = 1'b0;
      wr(3'd0, 8'b00_01_1_100);
      pulses = 0;
      for (int k = 0; k < 4200; k++) begin @(negedge clk); pulses += int'(irq_ovf); end
      check("R10 one overflow pulse", pulses, 1);
      rd_cnt(v); check("R6 counter wrapped and runs", int'(v > 0 && v < 40), 1);
      wr(3'd0, 8'b00_01_1_000);
      pulses = 0;
      for (int k = 0; k < 4200; k++) begin @(negedge clk); pulses += int'(irq_ovf); end
      check("R10 overflow disabled", pulses, 0);

      // R11 register map writes and counter read-only
      wr(3'd0, 8'b11_01_1_000);
      wr(3'd2, 8'hFF);
      rd(3'd2, v); check("R11 data high pad", v, 3);
      wr(3'd3, 8'h7E);
      rd(3'd3, v); check("R11 counter read-only", v, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule